// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM interface. It drives the command and address pins from reset until the memory is ready for normal use. After reset it holds the bus at NOP for a power-up wait. The length of that wait is set in microseconds and converted to clock cycles from the clock-frequency parameter. It then closes every bank with a precharge-all command and runs two auto-refresh cycles. Last, it programs the mode register with a word built from separately supplied fields.

A timer paces each step. The timer enforces the row-precharge time after the precharge, the refresh cycle time after each refresh, and the mode-register settle time after the load. Every cycle between commands carries a NOP. When the final settle time ends, a done flag rises and stays high until the next reset. The controller's normal traffic logic can wait on that flag. Read and write traffic, periodic refresh and the data path are handled by other blocks.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, the command pins show NOP (cs_no=0, ras_no=1, cas_no=1, we_no=1), addr_o and ba_o are zero and done_o is low.
- R2: After reset is released, exactly PWR_CYC = CLK_MHZ*PWRUP_US consecutive cycles of NOP are driven before any other command.
- R3: The first command after the wait is PRECHARGE (cs,ras,cas,we = 0010) with addr_o bit 10 high and every other address bit zero.
- R4: The first AUTO REFRESH (0001) is issued T_RP cycles after the precharge. The second is issued T_RC cycles after the first.
- R5: LOAD MODE REGISTER (0000) is issued T_RC cycles after the second refresh. Exactly two refreshes precede it after reset.
- R6: During LOAD MODE REGISTER, addr_o[2:0] is the burst length, addr_o[3] the burst type, addr_o[6:4] the CAS latency, addr_o[8:7] the operating mode and addr_o[9] the write-burst mode. All higher address bits and ba_o are zero.
- R7: Every cycle that is not one of the four commands above carries NOP with a zero address.
- R8: done_o rises T_MRD cycles after LOAD MODE REGISTER. From then on it stays high and the command pins stay at NOP until reset.
- R9: Asserting reset at any point of the sequence aborts it. The full sequence restarts from the power-up wait when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| burst_len_i | input | 3 | Burst length field of the mode word |
| burst_type_i | input | 1 | Burst type field (sequential/interleaved) |
| cas_lat_i | input | 3 | CAS latency field |
| op_mode_i | input | 2 | Operating mode field |
| wr_burst_i | input | 1 | Write-burst mode field |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus (A10 selects all banks on precharge) |
| ba_o | output | BA_W | Bank address |
| done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
The assertions check on every cycle the properties that hold at each edge:
- no command before the power-up wait has fully elapsed;
- A10 high on the precharge;
- two refreshes counted before the mode load;
- clean upper address and bank bits on the mode load;
- every command is followed by a NOP;
- done stays high and only NOP is driven once done is set.

The bench's scoreboard checks what the assertions cannot: the exact cycle of every command and of done, the mode-word bit positions under several field patterns, and a restart after reset is asserted mid-sequence.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [3:0] {
    ST_WAIT, ST_PRE, ST_TRP, ST_REF1, ST_TRC1,
    ST_REF2, ST_TRC2, ST_LMR, ST_TMRD, ST_DONE
  } init_st_e;

  // packed MSB..LSB matches mode word bits 9..0
  typedef struct packed {
    logic       wr_burst;
    logic [1:0] op_mode;
    logic [2:0] cas_lat;
    logic       burst_type;
    logic [2:0] burst_len;
  } mode_fields_t;

  localparam int unsigned MODE_FIELD_W = $bits(mode_fields_t);
  localparam int unsigned A10_BIT      = 10;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RC  = 9,
  parameter int unsigned T_MRD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output init_st_e         state_o
);

  // gap states last T-1 cycles, so the timer loads T-2
  localparam logic [CNT_W-1:0] GAP_RP  = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] GAP_RC  = CNT_W'(T_RC - 2);
  localparam logic [CNT_W-1:0] GAP_MRD = CNT_W'(T_MRD - 2);

  init_st_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_val_o = '0;
    unique case (state_q)
      ST_WAIT: state_d = ST_PRE;
      ST_PRE:  begin state_d = ST_TRP;  load_val_o = GAP_RP;  end
      ST_TRP:  state_d = ST_REF1;
      ST_REF1: begin state_d = ST_TRC1; load_val_o = GAP_RC;  end
      ST_TRC1: state_d = ST_REF2;
      ST_REF2: begin state_d = ST_TRC2; load_val_o = GAP_RC;  end
      ST_TRC2: state_d = ST_LMR;
      ST_LMR:  begin state_d = ST_TMRD; load_val_o = GAP_MRD; end
      ST_TMRD: state_d = ST_DONE;
      default: state_d = ST_DONE;
    endcase
  end

  assign load_o = zero_i && (state_q != ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ST_WAIT;
    else if (load_o) state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  mode_fields_t      fields_i,
  output logic [ADDR_W-1:0] word_o
);

  localparam int unsigned PAD_W = ADDR_W - MODE_FIELD_W;

  // reserved and unused upper bits forced low
  assign word_o = {{PAD_W{1'b0}}, fields_i};

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 133,
  parameter int unsigned PWRUP_US = 100,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_RC     = 9,
  parameter int unsigned T_MRD    = 2,
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned BA_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [1:0]        op_mode_i,
  input  logic              wr_burst_i,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              done_o
);

  localparam int unsigned PWR_CYC = CLK_MHZ * PWRUP_US;
  localparam int unsigned MAX_T   = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                                  : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int unsigned MAX_CNT = (PWR_CYC > MAX_T) ? PWR_CYC : MAX_T;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  logic             tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  init_st_e         state;
  mode_fields_t     fields;
  logic [ADDR_W-1:0] mode_word;
  sdram_cmd_e       cmd;

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(PWR_CYC - 1)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sdram_init_fsm #(.CNT_W(CNT_W), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zero_i     (tmr_zero),
    .load_o     (tmr_load),
    .load_val_o (tmr_val),
    .state_o    (state)
  );

  assign fields = '{wr_burst:   wr_burst_i,
                    op_mode:    op_mode_i,
                    cas_lat:    cas_lat_i,
                    burst_type: burst_type_i,
                    burst_len:  burst_len_i};

  sdram_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .fields_i (fields),
    .word_o   (mode_word)
  );

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    unique case (state)
      ST_PRE: begin
        cmd             = CMD_PRE;
        addr_o[A10_BIT] = 1'b1;
      end
      ST_REF1, ST_REF2: cmd = CMD_REF;
      ST_LMR: begin
        cmd    = CMD_LMR;
        addr_o = mode_word;
      end
      default: cmd = CMD_NOP;
    endcase
  end

  assign {cs_no, ras_no, cas_no, we_no} = cmd;
  assign ba_o   = '0;
  assign done_o = (state == ST_DONE);

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int unsigned PWR_CYC = 13300,
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned BA_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BA_W-1:0]   ba_o,
  input logic              done_o
);

  localparam int unsigned CYC_W = $clog2(PWR_CYC + 1);

  logic [3:0]       cmd;
  logic [CYC_W-1:0] cyc_q;
  logic [1:0]       ref_q;

  assign cmd = {cs_no, ras_no, cas_no, we_no};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      ref_q <= '0;
    end else begin
      if (cyc_q != CYC_W'(PWR_CYC)) cyc_q <= cyc_q + 1'b1;
      if (cmd == 4'b0001 && ref_q != 2'd3) ref_q <= ref_q + 1'b1;
    end
  end

  // R2
  wait_elapsed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != 4'b0111) |-> (cyc_q == CYC_W'(PWR_CYC)));

  // R3
  pre_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0010) |-> (addr_o[10] && ref_q == 2'd0));

  // R5
  two_refresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0000) |-> (ref_q == 2'd2));

  // R6
  mode_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0000) |-> (ba_o == '0 && addr_o[ADDR_W-1:10] == '0));

  // R7
  nop_after_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != 4'b0111) |=> (cmd == 4'b0111));

  // R8
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd == 4'b0111));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .PWR_CYC (PWR_CYC),
  .ADDR_W  (ADDR_W),
  .BA_W    (BA_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_no  (cs_no),
  .ras_no (ras_no),
  .cas_no (cas_no),
  .we_no  (we_no),
  .addr_o (addr_o),
  .ba_o   (ba_o),
  .done_o (done_o)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

  localparam int CLK_MHZ  = 125;
  localparam int PWRUP_US = 100;
  localparam int T_RP     = 3;
  localparam int T_RC     = 9;
  localparam int T_MRD    = 2;
  localparam int ADDR_W   = 13;
  localparam int BA_W     = 2;
  localparam int PWR_CYC  = CLK_MHZ * PWRUP_US;

  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] LMR = 4'b0000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] burst_len = '0;
  logic       burst_type = 1'b0;
  logic [2:0] cas_lat = '0;
  logic [1:0] op_mode = '0;
  logic       wr_burst = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, done;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0]   ba;

  int tests = 0, fails = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [3:0]        cmd;
    logic [ADDR_W-1:0] addr;
    logic              done;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];

  always #4 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .ADDR_W(ADDR_W), .BA_W(BA_W)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .burst_len_i(burst_len), .burst_type_i(burst_type), .cas_lat_i(cas_lat),
    .op_mode_i(op_mode), .wr_burst_i(wr_burst),
    .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .addr_o(addr), .ba_o(ba), .done_o(done)
  );

  task automatic push(input logic [3:0] c, input logic [ADDR_W-1:0] a,
                      input logic d, input string r);
    exp_q.push_back('{cmd: c, addr: a, done: d});
    req_q.push_back(r);
  endtask

  // full expected stream, truncated after max_items entries
  task automatic push_seq(input logic [ADDR_W-1:0] mw, input int max_items, input int n_done);
    exp_t tmp[$];
    string rtmp[$];
    logic [ADDR_W-1:0] a10 = '0;
    a10[10] = 1'b1;
    for (int i = 0; i < PWR_CYC; i++) begin tmp.push_back('{NOP, '0, 1'b0}); rtmp.push_back("R2"); end
    tmp.push_back('{PRE, a10, 1'b0}); rtmp.push_back("R3");
    for (int i = 0; i < T_RP - 1; i++) begin tmp.push_back('{NOP, '0, 1'b0}); rtmp.push_back("R7"); end
    tmp.push_back('{REF, '0, 1'b0}); rtmp.push_back("R4");
    for (int i = 0; i < T_RC - 1; i++) begin tmp.push_back('{NOP, '0, 1'b0}); rtmp.push_back("R7"); end
    tmp.push_back('{REF, '0, 1'b0}); rtmp.push_back("R4");
    for (int i = 0; i < T_RC - 1; i++) begin tmp.push_back('{NOP, '0, 1'b0}); rtmp.push_back("R7"); end
    tmp.push_back('{LMR, mw, 1'b0}); rtmp.push_back("R5/R6");
    for (int i = 0; i < T_MRD - 1; i++) begin tmp.push_back('{NOP, '0, 1'b0}); rtmp.push_back("R7"); end
    for (int i = 0; i < n_done; i++) begin tmp.push_back('{NOP, '0, 1'b1}); rtmp.push_back("R8"); end
    for (int i = 0; i < tmp.size() && i < max_items; i++) push(tmp[i].cmd, tmp[i].addr, tmp[i].done, rtmp[i]);
  endtask

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    #1;
    if (mon_on && exp_q.size() > 0) begin
      exp_t e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      tests++;
      if ({cs_n, ras_n, cas_n, we_n} != e.cmd || addr != e.addr || ba != '0 || done != e.done) begin
        fails++;
        $display("FAIL %s: cmd=%b addr=%h ba=%h done=%b expected cmd=%b addr=%h ba=0 done=%b",
                 r, {cs_n, ras_n, cas_n, we_n}, addr, ba, done, e.cmd, e.addr, e.done);
      end
    end
  end

  task automatic check_reset(input string r);
    tests++;
    if ({cs_n, ras_n, cas_n, we_n} != NOP || addr != '0 || ba != '0 || done != 1'b0) begin
      fails++;
      $display("FAIL %s: cmd=%b addr=%h ba=%h done=%b expected cmd=0111 addr=0 ba=0 done=0",
               r, {cs_n, ras_n, cas_n, we_n}, addr, ba, done);
    end
  endtask

  task automatic set_fields(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                            input logic [1:0] om, input logic wb);
    burst_len = bl; burst_type = bt; cas_lat = cl; op_mode = om; wr_burst = wb;
  endtask

  // R6: expected word from the stated bit positions
  function automatic logic [ADDR_W-1:0] mword(input logic [2:0] bl, input logic bt,
                                              input logic [2:0] cl, input logic [1:0] om, input logic wb);
    logic [ADDR_W-1:0] w = '0;
    w[2:0] = bl; w[3] = bt; w[6:4] = cl; w[8:7] = om; w[9] = wb;
    return w;
  endfunction

  task automatic release_and_drain();
    @(negedge clk);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    while (exp_q.size() > 0) @(negedge clk);
    #2;
    mon_on = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset("R1");

    // run 1: mixed field pattern
    set_fields(3'b011, 1'b1, 3'b010, 2'b00, 1'b1);
    push_seq(mword(3'b011, 1'b1, 3'b010, 2'b00, 1'b1), 1 << 30, 20);
    release_and_drain();

    // R1 / R9: reset while done, outputs return to idle
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check_reset("R1 after done");

    // run 2: abort mid-sequence (after the first refresh)
    set_fields(3'b111, 1'b0, 3'b111, 2'b11, 1'b0);
    push_seq('0, PWR_CYC + T_RP + 3, 0);
    release_and_drain();
    rst_ni = 1'b0;
    #1;
    check_reset("R9 abort");

    // run 3: fresh full sequence, other field pattern
    set_fields(3'b100, 1'b0, 3'b101, 2'b10, 1'b0);
    push_seq(mword(3'b100, 1'b0, 3'b101, 2'b10, 1'b0), 1 << 30, 8);
    @(negedge clk);
    release_and_drain();

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

endmodule